// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a register bus and the serial shifter of one SPI channel. It holds a transmit FIFO that the bus fills and the shifter drains, and a receive FIFO that the shifter fills and the bus drains. Both fill levels, two ready flags, a transmit-done flag and a trailing-count-zero flag appear together in one status word.

Misuse of either FIFO is recorded in a sticky flag. Misuse means a push into a full FIFO or a pop from an empty one. A trailing timer flags a small remainder of receive data that stays below the receive ready level for too long. All sticky events are cleared by writing ones to a clear port. A single interrupt output combines the enabled sources. Two DMA request lines tell an external engine when a single or 4-beat transfer can proceed.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset both levels are zero and every sticky flag is clear. With the default parameters the status word reads 0xC0001: TX ready at bit 0, trailing-count-zero at bit 18 and transmit done at bit 19. `irq` is low while `int_en` is zero.
- R2: Words written to the TX FIFO leave through `tx_pop_data` in write order. The TX level is reported in status bits [6 +: LW], where LW = $clog2(DEPTH)+1.
- R3: A TX write while the TX FIFO holds DEPTH words is dropped and sets the sticky TX overrun flag, status bit 3.
- R4: A TX pop while the TX FIFO is empty presents zero on `tx_pop_data` and sets the sticky TX underrun flag, status bit 2.
- R5: Received words leave through `rx_rd_data` in push order, and the RX level is reported at status bits [RX_LVL_OFS +: LW]. A read from an empty RX FIFO returns zero and sets the sticky RX underrun flag, status bit 4.
- R6: An RX push while the RX FIFO is full is dropped and sets the sticky RX overrun flag, status bit 5.
- R7: Status bit 0 (TX ready) is 1 while the TX level is at most TX_RDY_LVL. Status bit 1 (RX ready) is 1 while the RX level is at least RX_RDY_LVL.
- R8: A `pend_clr_wr` pulse clears the sticky bits whose `pend_clr_data` bit is 1. The mapping is bit 0 trailing, bit 1 RX overrun, bit 2 RX underrun, bit 3 TX overrun, bit 4 TX underrun. A new event in the same cycle as its clear leaves the bit set.
- R9: `irq` is the OR of the sources ANDed with `int_en`. The enable bits are: 0 TX ready, 1 RX ready, 2 TX underrun, 3 TX overrun, 4 RX underrun, 5 RX overrun, 6 trailing event.
- R10: Every accepted RX push loads the trailing counter from `trail_reload`. The counter steps down once per clock while the RX FIFO is non-empty and below RX_RDY_LVL. The step from 1 to 0 sets the trailing sticky bit. Status bit RX_LVL_OFS+LW shows that the counter is zero.
- R11: Status bit RX_LVL_OFS+LW+1 (transmit done) is 1 only when the TX level is zero and `shifter_busy` is low.
- R12: `sw_rst` empties both FIFOs and zeroes the trailing counter. It leaves the sticky flags unchanged.
- R13: `dma_cfg` bit 1 enables `tx_dma_req` and bit 2 enables `rx_dma_req`. Bit 0 selects a 4-word burst. A request is raised when the TX free space, or the RX level, is at least 4 in burst mode, or at least 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous FIFO flush |
| tx_wr_en | input | 1 | Bus write into TX FIFO |
| tx_wr_data | input | DW | TX write data |
| tx_pop | input | 1 | Shifter takes a TX word |
| tx_pop_data | output | DW | Head of TX FIFO, zero when empty |
| shifter_busy | input | 1 | Shifter still sending the last word |
| rx_push | input | 1 | Shifter delivers an RX word |
| rx_push_data | input | DW | RX push data |
| rx_rd_en | input | 1 | Bus read from RX FIFO |
| rx_rd_data | output | DW | Head of RX FIFO, zero when empty |
| int_en | input | 7 | Per-source interrupt enables |
| pend_clr_wr | input | 1 | Write strobe of the clear port |
| pend_clr_data | input | 5 | Write-one-to-clear mask |
| trail_reload | input | 10 | Trailing counter reload value |
| dma_cfg | input | 3 | Burst select, TX DMA enable, RX DMA enable |
| status | output | RX_LVL_OFS+LW+2 | Status word |
| irq | output | 1 | Interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The bench fills each FIFO to exactly DEPTH words and then writes one more. A design that checks for fullness one entry late would corrupt the oldest word, and one that fails to drop the write would change the level. It pops and reads on empty FIFOs, which would expose a design that returns stale memory in place of zero. It clears one sticky bit while the others stay set, and it clears a bit in the same cycle that its event fires. A swapped clear map or a clear-wins priority shows up there. The trailing timer is sampled one cycle before and one cycle on the expected expiry, and again with the RX FIFO at its ready level. A counter that is off by one, or one that runs above the threshold, is caught by these samples.

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat #(
  parameter int DEPTH      = 16,
  parameter int DW         = 32,
  parameter int TX_RDY_LVL = 8,
  parameter int RX_RDY_LVL = 4,
  parameter int RX_LVL_OFS = 13,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1,
  localparam int SW = RX_LVL_OFS + LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          tx_wr_en,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  input  logic          shifter_busy,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_rd_en,
  output logic [DW-1:0] rx_rd_data,
  input  logic [6:0]    int_en,
  input  logic          pend_clr_wr,
  input  logic [4:0]    pend_clr_data,
  input  logic [9:0]    trail_reload,
  input  logic [2:0]    dma_cfg,
  output logic [SW-1:0] status,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [9:0]    trail_cnt;
  logic [4:0]    pend;

  wire tx_full  = tx_cnt == LW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == LW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_rdy   = tx_cnt <= LW'(TX_RDY_LVL);
  wire rx_rdy   = rx_cnt >= LW'(RX_RDY_LVL);

  wire tx_in  = tx_wr_en & ~tx_full  & ~sw_rst;
  wire tx_out = tx_pop   & ~tx_empty & ~sw_rst;
  wire rx_in  = rx_push  & ~rx_full  & ~sw_rst;
  wire rx_out = rx_rd_en & ~rx_empty & ~sw_rst;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= tx_wr_data;
    if (rx_in) rx_mem[rx_wp] <= rx_push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (sw_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= nxt(tx_wp);
      if (tx_out) tx_rp <= nxt(tx_rp);
      if (rx_in)  rx_wp <= nxt(rx_wp);
      if (rx_out) rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + LW'(tx_in) - LW'(tx_out);
      rx_cnt <= rx_cnt + LW'(rx_in) - LW'(rx_out);
    end
  end

  assign tx_pop_data = tx_empty ? '0 : tx_mem[tx_rp];
  assign rx_rd_data  = rx_empty ? '0 : rx_mem[rx_rp];

  wire trail_run = ~rx_empty & ~rx_rdy & (trail_cnt != '0);
  wire trail_hit = ~sw_rst & ~rx_in & trail_run & (trail_cnt == 10'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trail_cnt <= '0;
    else if (sw_rst)    trail_cnt <= '0;
    else if (rx_in)     trail_cnt <= trail_reload;
    else if (trail_run) trail_cnt <= trail_cnt - 1'b1;
  end

  // order of both vectors: trailing, rx overrun, rx underrun, tx overrun, tx underrun
  wire [4:0] pend_set = {
    tx_pop   & tx_empty & ~sw_rst,
    tx_wr_en & tx_full  & ~sw_rst,
    rx_rd_en & rx_empty & ~sw_rst,
    rx_push  & rx_full  & ~sw_rst,
    trail_hit
  };
  wire [4:0] pend_clr = pend_clr_wr ? pend_clr_data : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~pend_clr) | pend_set;
  end

  always_comb begin
    status = '0;
    status[0] = tx_rdy;
    status[1] = rx_rdy;
    status[2] = pend[4];
    status[3] = pend[3];
    status[4] = pend[2];
    status[5] = pend[1];
    status[6 +: LW] = tx_cnt;
    status[RX_LVL_OFS +: LW] = rx_cnt;
    status[RX_LVL_OFS + LW] = trail_cnt == '0;
    status[RX_LVL_OFS + LW + 1] = tx_empty & ~shifter_busy;
  end

  wire [6:0] int_src = {pend[0], pend[1], pend[2], pend[3], pend[4], rx_rdy, tx_rdy};
  assign irq = |(int_src & int_en);

  wire [LW-1:0] need   = dma_cfg[0] ? LW'(4) : LW'(1);
  wire [LW-1:0] tx_free = LW'(DEPTH) - tx_cnt;
  assign tx_dma_req = dma_cfg[1] & (tx_free >= need);
  assign rx_dma_req = dma_cfg[2] & (rx_cnt >= need);

endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk #(
  parameter int DEPTH      = 16,
  parameter int DW         = 32,
  parameter int RX_LVL_OFS = 13,
  parameter int LW         = 5,
  parameter int SW         = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          tx_wr_en,
  input logic          tx_pop,
  input logic [DW-1:0] tx_pop_data,
  input logic          rx_push,
  input logic          shifter_busy,
  input logic          pend_clr_wr,
  input logic [4:0]    pend_clr_data,
  input logic [6:0]    int_en,
  input logic [SW-1:0] status,
  input logic          irq
);
  wire [LW-1:0] txl = status[6 +: LW];
  wire [LW-1:0] rxl = status[RX_LVL_OFS +: LW];

  // R3
  tx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && !sw_rst && txl == LW'(DEPTH)) |=> status[3]);

  // R4
  tx_udr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && txl == '0) |-> tx_pop_data == '0);

  // R6
  rx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !sw_rst && rxl == LW'(DEPTH)) |=> status[5]);

  // R8
  tx_ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !(pend_clr_wr && pend_clr_data[3])) |=> status[3]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);

  // R11
  tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[RX_LVL_OFS + LW + 1] |-> (txl == '0 && !shifter_busy));

  // R12
  sw_rst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (txl == '0 && rxl == '0));

  // R2
  tx_lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txl <= LW'(DEPTH) && rxl <= LW'(DEPTH));
endmodule

bind spi_fifo_stat spi_fifo_stat_chk #(
  .DEPTH(DEPTH), .DW(DW), .RX_LVL_OFS(RX_LVL_OFS), .LW(LW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .tx_wr_en(tx_wr_en),
  .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_push(rx_push),
  .shifter_busy(shifter_busy), .pend_clr_wr(pend_clr_wr),
  .pend_clr_data(pend_clr_data), .int_en(int_en), .status(status), .irq(irq)
);

// File: tb/spi_fifo_stat_tb_top.sv
module spi_fifo_stat_tb_top;
  localparam int DW = 32;
  localparam int SW = 20;

  logic clk = 0, rst_n = 0, sw_rst = 0;
  logic tx_wr_en = 0, tx_pop = 0, shifter_busy = 0, rx_push = 0, rx_rd_en = 0;
  logic [DW-1:0] tx_wr_data = 0, rx_push_data = 0, tx_pop_data, rx_rd_data;
  logic [6:0] int_en = 0;
  logic pend_clr_wr = 0;
  logic [4:0] pend_clr_data = 0;
  logic [9:0] trail_reload = 0;
  logic [2:0] dma_cfg = 0;
  logic [SW-1:0] status;
  logic irq, tx_dma_req, rx_dma_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_fifo_stat dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] txl(); return 32'(status[6 +: 5]); endfunction
  function automatic logic [31:0] rxl(); return 32'(status[13 +: 5]); endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic tx_write(input logic [31:0] d);
    tx_wr_en = 1; tx_wr_data = d; tick(); tx_wr_en = 0;
  endtask
  task automatic tx_read(output logic [31:0] d);
    tx_pop = 1; #1 d = tx_pop_data; tick(); tx_pop = 0;
  endtask
  task automatic rx_put(input logic [31:0] d);
    rx_push = 1; rx_push_data = d; tick(); rx_push = 0;
  endtask
  task automatic rx_get(output logic [31:0] d);
    rx_rd_en = 1; #1 d = rx_rd_data; tick(); rx_rd_en = 0;
  endtask
  task automatic clr(input logic [4:0] m);
    pend_clr_wr = 1; pend_clr_data = m; tick(); pend_clr_wr = 0;
  endtask
  task automatic flush(); sw_rst = 1; tick(); sw_rst = 0; clr(5'h1F); endtask

  task automatic t_reset();
    check("R1 status", 32'(status), 32'hC0001);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] d;
    tx_write(32'hA1); tx_write(32'hB2); tx_write(32'hC3);
    check("R2 tx level", txl(), 3);
    tx_read(d); check("R2 first", d, 32'hA1);
    tx_read(d); check("R2 second", d, 32'hB2);
    tx_read(d); check("R2 third", d, 32'hC3);
  endtask

  task automatic t_tx_ovr();
    logic [31:0] d;
    flush();
    for (int i = 0; i < 16; i++) tx_write(32'(i + 100));
    check("R2 full level", txl(), 16);
    check("R7 tx not ready", 32'(status[0]), 0);
    check("R3 no flag yet", 32'(status[3]), 0);
    tx_write(32'hDEAD);
    check("R3 tx overrun", 32'(status[3]), 1);
    check("R3 level kept", txl(), 16);
    for (int i = 0; i < 16; i++) begin
      tx_read(d);
      if (i == 0) check("R3 oldest kept", d, 100);
      if (i == 15) check("R3 newest dropped", d, 115);
    end
  endtask

  task automatic t_tx_udr();
    logic [31:0] d;
    check("R4 no underrun yet", 32'(status[2]), 0);
    tx_read(d);
    check("R4 zero data", d, 0);
    check("R4 tx underrun", 32'(status[2]), 1);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    flush();
    rx_put(32'h11); rx_put(32'h22);
    check("R5 rx level", rxl(), 2);
    check("R7 rx not ready", 32'(status[1]), 0);
    rx_put(32'h33); rx_put(32'h44);
    check("R7 rx ready", 32'(status[1]), 1);
    rx_get(d); check("R5 first", d, 32'h11);
    rx_get(d); check("R5 second", d, 32'h22);
    rx_get(d); rx_get(d); check("R5 fourth", d, 32'h44);
    rx_get(d); check("R5 empty zero", d, 0);
    check("R5 rx underrun", 32'(status[4]), 1);
  endtask

  task automatic t_rx_ovr();
    logic [31:0] d;
    flush();
    for (int i = 0; i < 17; i++) rx_put(32'(i + 1));
    check("R6 rx overrun", 32'(status[5]), 1);
    check("R6 level", rxl(), 16);
    rx_get(d); check("R6 oldest kept", d, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    tx_write(1); tx_read(d); tx_read(d);
    rx_get(d);
    for (int i = 0; i < 20; i++) rx_get(d);
    for (int i = 0; i < 17; i++) tx_write(1);
    check("R8 four flags set", 32'(status[5:2]), 4'hF);
    clr(5'b00010);
    check("R8 only rx overrun cleared", 32'(status[5:2]), 4'h7);
    clr(5'b11100);
    check("R8 rest cleared", 32'(status[5:2]), 4'h0);
    rx_rd_en = 1; pend_clr_wr = 1; pend_clr_data = 5'b00100;
    tick(); rx_rd_en = 0; pend_clr_wr = 0;
    check("R8 set wins over clear", 32'(status[4]), 1);
  endtask

  task automatic t_irq();
    flush();
    int_en = 7'h20;
    check("R9 irq quiet", 32'(irq), 0);
    for (int i = 0; i < 17; i++) rx_put(0);
    check("R9 irq on rx overrun", 32'(irq), 1);
    int_en = 7'h00; #1;
    check("R9 irq masked", 32'(irq), 0);
    flush();
    int_en = 7'h01; #1;
    check("R9 irq on tx ready", 32'(irq), 1);
    int_en = 0;
  endtask

  task automatic t_trail();
    flush();
    int_en = 7'h40; trail_reload = 10'd5;
    rx_put(32'h5);
    repeat (4) tick();
    check("R10 not yet expired", 32'(irq), 0);
    check("R10 count nonzero", 32'(status[18]), 0);
    tick();
    check("R10 trailing event", 32'(irq), 1);
    check("R10 count zero", 32'(status[18]), 1);
    flush();
    for (int i = 0; i < 4; i++) rx_put(32'(i));
    repeat (10) tick();
    check("R10 idle at ready level", 32'(irq), 0);
    check("R10 count held", 32'(status[18]), 0);
    int_en = 0;
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    flush();
    tx_write(7); tx_write(8); rx_put(9);
    rx_get(d); rx_get(d);
    sw_rst = 1; tick(); sw_rst = 0;
    check("R12 tx level cleared", txl(), 0);
    check("R12 rx level cleared", rxl(), 0);
    check("R12 sticky kept", 32'(status[4]), 1);
  endtask

  task automatic t_txdone();
    flush();
    check("R11 idle done", 32'(status[19]), 1);
    shifter_busy = 1; #1;
    check("R11 busy not done", 32'(status[19]), 0);
    shifter_busy = 0;
    tx_write(1);
    check("R11 data left not done", 32'(status[19]), 0);
  endtask

  task automatic t_dma();
    flush();
    dma_cfg = 3'b010; #1;
    check("R13 tx single req", 32'(tx_dma_req), 1);
    for (int i = 0; i < 13; i++) tx_write(1);
    dma_cfg = 3'b011; #1;
    check("R13 tx burst blocked", 32'(tx_dma_req), 0);
    dma_cfg = 3'b010; #1;
    check("R13 tx single with 3 free", 32'(tx_dma_req), 1);
    dma_cfg = 3'b100; #1;
    check("R13 rx empty no req", 32'(rx_dma_req), 0);
    check("R13 tx disabled", 32'(tx_dma_req), 0);
    rx_put(1);
    check("R13 rx single req", 32'(rx_dma_req), 1);
    dma_cfg = 3'b101; #1;
    check("R13 rx burst blocked", 32'(rx_dma_req), 0);
    rx_put(2); rx_put(3); rx_put(4);
    check("R13 rx burst req", 32'(rx_dma_req), 1);
    dma_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_ovr();
    t_tx_udr();
    t_rx();
    t_rx_ovr();
    t_clear();
    t_irq();
    t_trail();
    t_swrst();
    t_txdone();
    t_dma();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule